// File: doc/BRIEF.md
# Rectangular Bitmap Transfer Sequencer

This block steers a memory-to-memory engine that moves a rectangular bitmap. It walks a rectangle pixel by pixel, line by line, and for each pixel issues the reads and the write that the selected operation needs. Three independent address streams are kept: foreground source, background source and destination. Each stream has a base address and a line offset in pixels. All streams share one width, one height and one pixel size in bytes. Pixel data does not pass through the block; an external conversion and blending path consumes the read data and supplies the write data. In fill operations the block presents the fill colour alongside the write instead.

Software places a sub-rectangle by pointing a stream base at `image_base + (X + image_width * Y) * bytes_per_pixel`. It sets that stream's line offset to `image_width - width`. A start pulse latches the whole configuration. A suspend level holds back new requests, and an abort pulse ends the operation early. Four sticky flags report completion, the watermark line, bus errors and illegal configurations. Each flag has its own clear input.

Top module: `blit2d_ctrl`

## Requirements
- R1: Mode 0 (fill) issues no reads. It issues width*height writes in raster order, each with `wr_fill`=1 and `wr_color` equal to the colour latched at start.
- R2: Modes 1 (copy) and 2 (copy with conversion) issue, per pixel, one foreground read (`rd_bg`=0) followed by one write with `wr_fill`=0. They issue no background reads.
- R3: Mode 3 (blend) issues, per pixel, a foreground read, then a background read (`rd_bg`=1), then a write.
- R4: Each stream's first address is its base. Within a line, each address is the previous one plus bytes_per_pixel. After the last pixel of a line, the stream adds a further line_offset*bytes_per_pixel.
- R5: A start pulse while idle with a legal configuration latches all configuration inputs and makes `busy` rise on the next clock edge. A start pulse while busy is ignored.
- R6: A start with width 0, height 0, or bytes_per_pixel outside 1..4 sets `flag_cerr` on the next edge. It makes no access and leaves `busy` low.
- R7: `flag_done` is set on the edge where the last write handshake of the rectangle completes, and `busy` falls on that same edge.
- R8: `flag_wm` is set on the edge where the write of the last pixel of line `cfg_wm_line` (lines counted from 0) completes. If that line lies beyond the height, the flag is never set.
- R9: While `suspend` is high, no new request is raised. A request that is already raised stays up until it is accepted. When suspend drops, the transfer continues where it stopped.
- R10: After an abort pulse, the block makes at most the one handshake already outstanding and then returns to idle. It does not set `flag_done`.
- R11: `rd_err` or `wr_err` during a handshake sets `flag_terr` and returns the block to idle without setting `flag_done`.
- R12: After reset, all flags are 0. Each flag is cleared only by its own clear input, and a set in the same cycle takes precedence over the clear.
- R13: A raised request keeps its address and kind unchanged until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 fill, 1 copy, 2 copy+convert, 3 blend |
| cfg_width | input | DW | Pixels per line |
| cfg_height | input | DW | Lines |
| cfg_bpp | input | 3 | Bytes per pixel, 1..4 |
| cfg_fg_base | input | AW | Foreground start address |
| cfg_bg_base | input | AW | Background start address |
| cfg_out_base | input | AW | Destination start address |
| cfg_fg_loff | input | DW | Foreground line offset, pixels |
| cfg_bg_loff | input | DW | Background line offset, pixels |
| cfg_out_loff | input | DW | Destination line offset, pixels |
| cfg_color | input | CW | Fill colour |
| cfg_wm_line | input | DW | Watermark line number |
| start | input | 1 | Launch pulse |
| suspend | input | 1 | Pause level |
| abort | input | 1 | Terminate pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_bg | output | 1 | 1 = background read, 0 = foreground read |
| rd_ready | input | 1 | Read accepted |
| rd_err | input | 1 | Bus error on the accepted read |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_fill | output | 1 | Write data is `wr_color` instead of pipeline data |
| wr_color | output | CW | Latched fill colour |
| wr_ready | input | 1 | Write accepted |
| wr_err | input | 1 | Bus error on the accepted write |
| busy | output | 1 | Operation in progress |
| flag_done | output | 1 | Transfer complete |
| flag_wm | output | 1 | Watermark line written |
| flag_terr | output | 1 | Bus error seen |
| flag_cerr | output | 1 | Illegal configuration at start |
| clr_done | input | 1 | Clear `flag_done` |
| clr_wm | input | 1 | Clear `flag_wm` |
| clr_terr | input | 1 | Clear `flag_terr` |
| clr_cerr | input | 1 | Clear `flag_cerr` |

## Verification
`busy` and `flag_cerr` respond on the first edge after the start pulse. The first request comes up one edge after `busy`. Each later request comes up one edge after the previous handshake. Every flag register updates on the edge that carries the handshake causing it, so it is visible in the next half cycle. The bench decides ready and error for each cycle at the falling edge and records the handshake that the following rising edge will perform. It checks the watermark flag at each falling edge against the write count already committed, and it drives and checks everything else one time unit after a rising edge.

// File: rtl/blit2d_pkg.sv
package blit2d_pkg;

    typedef enum logic [1:0] {
        MODE_FILL  = 2'd0,
        MODE_COPY  = 2'd1,
        MODE_CONV  = 2'd2,
        MODE_BLEND = 2'd3
    } blit_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_FG = 2'd1,
        ST_RD_BG = 2'd2,
        ST_WR    = 2'd3
    } blit_state_e;

    localparam int NSTREAM = 3;
    localparam int STR_FG  = 0;
    localparam int STR_BG  = 1;
    localparam int STR_OUT = 2;
    localparam int MAX_BPP = 4;

    // per-stream pointer control
    typedef struct packed {
        logic load;
        logic adv;
        logic eol;
    } ptr_ctl_t;

    function automatic logic cfg_legal(input logic [31:0] w, input logic [31:0] h,
                                       input logic [2:0] bpp);
        return (w != 32'd0) && (h != 32'd0) && (bpp != 3'd0) && (32'(bpp) <= MAX_BPP);
    endfunction

    function automatic blit_state_e first_state(input blit_mode_e m);
        return (m == MODE_FILL) ? ST_WR : ST_RD_FG;
    endfunction

endpackage

// File: rtl/blit2d_addr_gen.sv
module blit2d_addr_gen
    import blit2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  ptr_ctl_t      ctl,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] loff,
    input  logic [2:0]    bpp,
    output logic [AW-1:0] addr
);
    localparam int SW = DW + 3;

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] skip_q;
    logic [AW-1:0] step_q;
    logic [SW-1:0] skip_w;

    assign skip_w = SW'(loff) * SW'(bpp);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            skip_q <= '0;
            step_q <= '0;
        end else if (ctl.load) begin
            ptr_q  <= base;
            skip_q <= AW'(skip_w);
            step_q <= AW'(bpp);
        end else if (ctl.adv) begin
            ptr_q <= ptr_q + step_q + (ctl.eol ? skip_q : '0);
        end
    end

    assign addr = ptr_q;

endmodule

// File: rtl/blit2d_seq.sv
module blit2d_seq
    import blit2d_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [DW-1:0] wm_line,
    input  logic [2:0]    bpp,
    input  logic          start,
    input  logic          suspend,
    input  logic          abort,
    input  logic          rd_ready,
    input  logic          rd_err,
    input  logic          wr_ready,
    input  logic          wr_err,
    input  logic          clr_done,
    input  logic          clr_wm,
    input  logic          clr_terr,
    input  logic          clr_cerr,
    output logic          rd_req,
    output logic          rd_bg,
    output logic          wr_req,
    output logic          wr_fill,
    output logic          busy,
    output ptr_ctl_t      ctl_fg,
    output ptr_ctl_t      ctl_bg,
    output ptr_ctl_t      ctl_out,
    output logic          flag_done,
    output logic          flag_wm,
    output logic          flag_terr,
    output logic          flag_cerr
);
    localparam logic [DW-1:0] ONE = DW'(1);

    blit_state_e   state_q, state_d;
    blit_mode_e    mode_q;
    logic [DW-1:0] w_q, h_q, wm_q, x_q, y_q;
    logic          req_q, req_d, abort_q;

    logic hs_rd, hs_wr, hs, bus_err, eol, last, stop, launch, legal, load;
    logic set_done, set_wm, set_terr, set_cerr;

    assign rd_req  = req_q && ((state_q == ST_RD_FG) || (state_q == ST_RD_BG));
    assign rd_bg   = (state_q == ST_RD_BG);
    assign wr_req  = req_q && (state_q == ST_WR);
    assign wr_fill = wr_req && (mode_q == MODE_FILL);
    assign busy    = (state_q != ST_IDLE);

    assign hs_rd   = rd_req && rd_ready;
    assign hs_wr   = wr_req && wr_ready;
    assign hs      = hs_rd || hs_wr;
    assign bus_err = (hs_rd && rd_err) || (hs_wr && wr_err);
    assign eol     = (x_q == w_q - ONE);
    assign last    = eol && (y_q == h_q - ONE);
    assign stop    = abort || abort_q;
    assign launch  = (state_q == ST_IDLE) && start;
    assign legal   = cfg_legal(32'(width), 32'(height), bpp);
    assign load    = launch && legal;

    always_comb begin
        ctl_fg.load  = load;
        ctl_fg.adv   = hs_rd && !rd_bg && !rd_err;
        ctl_fg.eol   = eol;
        ctl_bg.load  = load;
        ctl_bg.adv   = hs_rd && rd_bg && !rd_err;
        ctl_bg.eol   = eol;
        ctl_out.load = load;
        ctl_out.adv  = hs_wr && !wr_err;
        ctl_out.eol  = eol;
    end

    always_comb begin
        state_d = state_q;
        req_d   = req_q;
        if (state_q == ST_IDLE) begin
            req_d = 1'b0;
            if (load) begin
                state_d = first_state(blit_mode_e'(mode));
            end
        end else if (!req_q) begin
            if (stop) begin
                state_d = ST_IDLE;
            end else if (!suspend) begin
                req_d = 1'b1;
            end
        end else if (hs) begin
            req_d = 1'b0;
            if (bus_err || stop) begin
                state_d = ST_IDLE;
            end else begin
                case (state_q)
                    ST_RD_FG: state_d = (mode_q == MODE_BLEND) ? ST_RD_BG : ST_WR;
                    ST_RD_BG: state_d = ST_WR;
                    default:  state_d = last ? ST_IDLE : first_state(mode_q);
                endcase
            end
        end
    end

    assign set_done = hs_wr && !wr_err && last && !stop;
    assign set_wm   = hs_wr && !wr_err && eol && (y_q == wm_q);
    assign set_terr = bus_err;
    assign set_cerr = launch && !legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
            abort_q <= 1'b0;
            mode_q  <= MODE_FILL;
            w_q     <= '0;
            h_q     <= '0;
            wm_q    <= '0;
            x_q     <= '0;
            y_q     <= '0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
            abort_q <= (state_d != ST_IDLE) && (abort_q || abort);
            if (load) begin
                mode_q <= blit_mode_e'(mode);
                w_q    <= width;
                h_q    <= height;
                wm_q   <= wm_line;
                x_q    <= '0;
                y_q    <= '0;
            end else if (ctl_out.adv) begin
                if (eol) begin
                    x_q <= '0;
                    y_q <= y_q + ONE;
                end else begin
                    x_q <= x_q + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_done <= 1'b0;
            flag_wm   <= 1'b0;
            flag_terr <= 1'b0;
            flag_cerr <= 1'b0;
        end else begin
            flag_done <= set_done ? 1'b1 : (clr_done ? 1'b0 : flag_done);
            flag_wm   <= set_wm   ? 1'b1 : (clr_wm   ? 1'b0 : flag_wm);
            flag_terr <= set_terr ? 1'b1 : (clr_terr ? 1'b0 : flag_terr);
            flag_cerr <= set_cerr ? 1'b1 : (clr_cerr ? 1'b0 : flag_cerr);
        end
    end

    // R13
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ready |=> rd_req && $stable(rd_bg));
    // R13
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ready |=> wr_req);
    // R1
    fill_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        busy && (mode_q == MODE_FILL) |-> !rd_req);
    // R2
    bg_only_blend_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_bg |-> mode_q == MODE_BLEND);
    // R6
    cerr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) && start && !legal |=> !busy && flag_cerr);
    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_done) |-> $past(hs_wr) && !busy);
    // R9
    suspend_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> !$past(suspend));
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        abort_q && !req_q |=> !busy);
    // R11
    terr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> !busy && flag_terr);

endmodule

// File: rtl/blit2d_ctrl.sv
module blit2d_ctrl
    import blit2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 12,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_mode,
    input  logic [DW-1:0] cfg_width,
    input  logic [DW-1:0] cfg_height,
    input  logic [2:0]    cfg_bpp,
    input  logic [AW-1:0] cfg_fg_base,
    input  logic [AW-1:0] cfg_bg_base,
    input  logic [AW-1:0] cfg_out_base,
    input  logic [DW-1:0] cfg_fg_loff,
    input  logic [DW-1:0] cfg_bg_loff,
    input  logic [DW-1:0] cfg_out_loff,
    input  logic [CW-1:0] cfg_color,
    input  logic [DW-1:0] cfg_wm_line,
    input  logic          start,
    input  logic          suspend,
    input  logic          abort,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          rd_bg,
    input  logic          rd_ready,
    input  logic          rd_err,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic          wr_fill,
    output logic [CW-1:0] wr_color,
    input  logic          wr_ready,
    input  logic          wr_err,
    output logic          busy,
    output logic          flag_done,
    output logic          flag_wm,
    output logic          flag_terr,
    output logic          flag_cerr,
    input  logic          clr_done,
    input  logic          clr_wm,
    input  logic          clr_terr,
    input  logic          clr_cerr
);
    localparam int NS = NSTREAM;

    ptr_ctl_t      ctl   [NS];
    logic [AW-1:0] bases [NS];
    logic [DW-1:0] loffs [NS];
    logic [AW-1:0] addrs [NS];
    logic [CW-1:0] color_q;

    assign bases[STR_FG]  = cfg_fg_base;
    assign bases[STR_BG]  = cfg_bg_base;
    assign bases[STR_OUT] = cfg_out_base;
    assign loffs[STR_FG]  = cfg_fg_loff;
    assign loffs[STR_BG]  = cfg_bg_loff;
    assign loffs[STR_OUT] = cfg_out_loff;

    blit2d_seq #(.DW(DW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_mode),
        .width     (cfg_width),
        .height    (cfg_height),
        .wm_line   (cfg_wm_line),
        .bpp       (cfg_bpp),
        .start     (start),
        .suspend   (suspend),
        .abort     (abort),
        .rd_ready  (rd_ready),
        .rd_err    (rd_err),
        .wr_ready  (wr_ready),
        .wr_err    (wr_err),
        .clr_done  (clr_done),
        .clr_wm    (clr_wm),
        .clr_terr  (clr_terr),
        .clr_cerr  (clr_cerr),
        .rd_req    (rd_req),
        .rd_bg     (rd_bg),
        .wr_req    (wr_req),
        .wr_fill   (wr_fill),
        .busy      (busy),
        .ctl_fg    (ctl[STR_FG]),
        .ctl_bg    (ctl[STR_BG]),
        .ctl_out   (ctl[STR_OUT]),
        .flag_done (flag_done),
        .flag_wm   (flag_wm),
        .flag_terr (flag_terr),
        .flag_cerr (flag_cerr)
    );

    for (genvar s = 0; s < NS; s++) begin : g_stream
        blit2d_addr_gen #(.AW(AW), .DW(DW)) agen_i (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl[s]),
            .base (bases[s]),
            .loff (loffs[s]),
            .bpp  (cfg_bpp),
            .addr (addrs[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            color_q <= '0;
        end else if (ctl[STR_OUT].load) begin
            color_q <= cfg_color;
        end
    end

    assign rd_addr  = rd_bg ? addrs[STR_BG] : addrs[STR_FG];
    assign wr_addr  = addrs[STR_OUT];
    assign wr_color = color_q;

    // R13
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ready |=> $stable(rd_addr));
    // R13
    wr_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ready |=> $stable(wr_addr) && $stable(wr_color));

endmodule

// File: tb/blit2d_ctrl_tb_top.sv
module blit2d_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 12;
    localparam int CW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_mode = '0;
    logic [DW-1:0] cfg_width = '0, cfg_height = '0, cfg_wm_line = '0;
    logic [2:0] cfg_bpp = '0;
    logic [AW-1:0] cfg_fg_base = '0, cfg_bg_base = '0, cfg_out_base = '0;
    logic [DW-1:0] cfg_fg_loff = '0, cfg_bg_loff = '0, cfg_out_loff = '0;
    logic [CW-1:0] cfg_color = '0;
    logic start = 0, suspend = 0, abort = 0;
    logic rd_req, rd_bg, wr_req, wr_fill, busy;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [CW-1:0] wr_color;
    logic rd_ready = 0, rd_err = 0, wr_ready = 0, wr_err = 0;
    logic flag_done, flag_wm, flag_terr, flag_cerr;
    logic clr_done = 0, clr_wm = 0, clr_terr = 0, clr_cerr = 0;

    int checks = 0;
    int errors = 0;
    logic [33:0] exp_q[$];
    bit exp_fill = 0;
    bit ready_rand = 1;
    int err_at = -1;
    int hs_idx = 0;
    int wcnt = 0;
    bit wm_watch = 0;
    int wm_target = 0;
    bit abort_watch = 0;
    int hs_after = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blit2d_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (.*);

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    // scoreboard monitor: decides ready/err for the coming edge and pops the matching item
    always @(negedge clk) begin
        bit rdy, hr, hw;
        logic [1:0] kind;
        logic [AW-1:0] a;
        logic [33:0] it;
        if (wm_watch)
            chk(flag_wm == (wcnt >= wm_target), "R8 watermark timing", flag_wm, wcnt >= wm_target);
        rdy = ready_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
        rd_ready = rdy;
        wr_ready = rdy;
        hr = rd_req && rdy;
        hw = wr_req && rdy;
        rd_err = 1'b0;
        wr_err = 1'b0;
        if (!rst && (hr || hw)) begin
            if (hs_idx == err_at) begin
                rd_err = hr;
                wr_err = hw;
            end
            hs_idx++;
            if (abort_watch) hs_after++;
            if (hw) wcnt++;
            kind = hw ? 2'd2 : (rd_bg ? 2'd1 : 2'd0);
            a = hw ? wr_addr : rd_addr;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 R2 R3 unexpected access", {kind, a}, 0);
            end else begin
                it = exp_q.pop_front();
                chk(it == {kind, a}, "R2 R3 R4 access kind/address", {kind, a}, it);
                if (hw) begin
                    chk(wr_fill == exp_fill, "R1 fill marker", wr_fill, exp_fill);
                    if (exp_fill) chk(wr_color == cfg_color, "R1 fill colour", wr_color, cfg_color);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic setcfg(input int m, input int w, input int h, input int b,
                          input int fb, input int bb, input int ob,
                          input int fl, input int bl, input int ol, input int wm);
        cfg_mode = 2'(m); cfg_width = DW'(w); cfg_height = DW'(h); cfg_bpp = 3'(b);
        cfg_fg_base = AW'(fb); cfg_bg_base = AW'(bb); cfg_out_base = AW'(ob);
        cfg_fg_loff = DW'(fl); cfg_bg_loff = DW'(bl); cfg_out_loff = DW'(ol);
        cfg_wm_line = DW'(wm);
    endtask

    task automatic push_op();
        int w = int'(cfg_width);
        int h = int'(cfg_height);
        int b = int'(cfg_bpp);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                if (cfg_mode != 2'd0)
                    exp_q.push_back({2'd0, cfg_fg_base + AW'((y * (w + int'(cfg_fg_loff)) + x) * b)});
                if (cfg_mode == 2'd3)
                    exp_q.push_back({2'd1, cfg_bg_base + AW'((y * (w + int'(cfg_bg_loff)) + x) * b)});
                exp_q.push_back({2'd2, cfg_out_base + AW'((y * (w + int'(cfg_out_loff)) + x) * b)});
            end
        end
        exp_fill = (cfg_mode == 2'd0);
    endtask

    task automatic clr_all();
        clr_done = 1; clr_wm = 1; clr_terr = 1; clr_cerr = 1;
        tick();
        clr_done = 0; clr_wm = 0; clr_terr = 0; clr_cerr = 0;
        tick();
    endtask

    task automatic launch();
        hs_idx = 0;
        wcnt = 0;
        start = 1;
        tick();
        start = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin
            tick();
            n++;
        end
        chk(!busy, "R7 operation did not finish", busy, 0);
    endtask

    task automatic run_op(input string tag);
        clr_all();
        push_op();
        launch();
        chk(busy, {tag, " busy after legal start"}, busy, 1);
        wait_idle();
        tick();
        chk(flag_done, {tag, " R7 done flag"}, flag_done, 1);
        chk(exp_q.size() == 0, {tag, " all accesses made"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R12 reset state
        chk(!flag_done && !flag_wm && !flag_terr && !flag_cerr, "R12 flags after reset",
            {flag_done, flag_wm, flag_terr, flag_cerr}, 0);
        chk(!busy && !rd_req && !wr_req, "R5 idle after reset", {busy, rd_req, wr_req}, 0);

        // R1 fill, R8 watermark on line 1
        cfg_color = 32'hA5C3_0F12;
        setcfg(0, 3, 2, 4, 0, 0, 'h1000, 0, 0, 5, 1);
        run_op("R1");
        chk(flag_wm, "R8 watermark line 1 of 2", flag_wm, 1);

        // R2 copy
        setcfg(1, 4, 3, 2, 'h2000, 0, 'h8000, 2, 0, 0, 9);
        run_op("R2 copy");
        chk(!flag_wm, "R8 watermark beyond height not set", flag_wm, 0);

        // R2 convert
        setcfg(2, 2, 2, 3, 'h3000, 0, 'h9000, 1, 0, 3, 0);
        run_op("R2 convert");

        // R3 blend with R8 exact timing on line 0
        setcfg(3, 3, 2, 1, 'h4000, 'h5000, 'hA000, 2, 4, 1, 0);
        clr_all();
        wm_target = 3;
        wm_watch = 1;
        push_op();
        launch();
        wait_idle();
        tick();
        wm_watch = 0;
        chk(flag_done, "R3 blend done", flag_done, 1);
        chk(exp_q.size() == 0, "R3 blend all accesses", exp_q.size(), 0);

        // R6 illegal configurations
        for (int k = 0; k < 3; k++) begin
            clr_all();
            if (k == 0) setcfg(1, 0, 2, 2, 0, 0, 0, 0, 0, 0, 0);
            if (k == 1) setcfg(1, 2, 0, 2, 0, 0, 0, 0, 0, 0, 0);
            if (k == 2) setcfg(1, 2, 2, 5, 0, 0, 0, 0, 0, 0, 0);
            launch();
            chk(flag_cerr, "R6 config error flag", flag_cerr, 1);
            chk(!busy, "R6 stays idle", busy, 0);
            repeat (4) tick();
            chk(!flag_done && !busy, "R6 no operation", {flag_done, busy}, 0);
        end

        // R12 individual clear, others untouched
        setcfg(0, 1, 1, 1, 0, 0, 'h40, 0, 0, 0, 0);
        push_op();
        launch();
        wait_idle();
        tick();
        clr_cerr = 1;
        tick();
        clr_cerr = 0;
        tick();
        chk(!flag_cerr, "R12 cerr cleared", flag_cerr, 0);
        chk(flag_done && flag_wm, "R12 other flags kept", {flag_done, flag_wm}, 2'b11);

        // R5 start while busy ignored
        setcfg(1, 4, 2, 2, 'h6000, 0, 'hB000, 0, 0, 0, 9);
        clr_all();
        push_op();
        launch();
        repeat (3) tick();
        cfg_out_base = 'hDEAD0; cfg_width = 7; cfg_bpp = 1;
        start = 1;
        tick();
        start = 0;
        wait_idle();
        tick();
        chk(exp_q.size() == 0 && flag_done, "R5 restart ignored", exp_q.size(), 0);

        // R9 suspend
        ready_rand = 0;
        setcfg(1, 4, 4, 2, 'h100, 0, 'h900, 0, 0, 0, 9);
        clr_all();
        push_op();
        launch();
        repeat (4) tick();
        suspend = 1;
        repeat (3) tick();
        for (int i = 0; i < 10; i++) begin
            chk(!rd_req && !wr_req && busy, "R9 no request while suspended",
                {rd_req, wr_req, busy}, 3'b001);
            tick();
        end
        suspend = 0;
        wait_idle();
        tick();
        chk(flag_done && exp_q.size() == 0, "R9 resumed to completion", exp_q.size(), 0);
        ready_rand = 1;

        // R10 abort
        setcfg(3, 8, 8, 4, 'h10000, 'h20000, 'h30000, 0, 0, 0, 9);
        clr_all();
        push_op();
        launch();
        repeat (7) tick();
        hs_after = 0;
        abort_watch = 1;
        abort = 1;
        tick();
        abort = 0;
        wait_idle();
        abort_watch = 0;
        tick();
        chk(hs_after <= 1, "R10 at most one handshake after abort", hs_after, 1);
        chk(!flag_done, "R10 no done after abort", flag_done, 0);
        repeat (4) tick();
        chk(!rd_req && !wr_req && !busy, "R10 quiet after abort", {rd_req, wr_req, busy}, 0);
        exp_q.delete();

        // R11 bus error on third handshake
        setcfg(3, 2, 2, 2, 'h700, 'h800, 'hC00, 0, 0, 0, 9);
        clr_all();
        push_op();
        err_at = 2;
        launch();
        wait_idle();
        tick();
        err_at = -1;
        chk(flag_terr, "R11 transfer error flag", flag_terr, 1);
        chk(!flag_done, "R11 no done after error", flag_done, 0);
        chk(exp_q.size() == 9, "R11 stopped after failing access", exp_q.size(), 9);
        exp_q.delete();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule